// File: doc/BRIEF.md
# Receive IQ Sample Packing Serializer

This block takes one receive I/Q sample at a time, 22 bits per rail, together with a gain-change flag and an 8-bit gain index. It builds a serial frame from them and shifts that frame out MSB first, one bit per clock. Two formats are available. The wide format gives 32 bits per rail and carries the unrounded sample with the gain fields beside it. The slim format gives 16 bits per rail and carries a 15-bit rounded sample followed by the gain-change flag. The gain fields pass through unchanged, whether they come from a slicer or from a gain-index source.

In two-lane operation, I leaves on lane 0 and Q leaves on lane 1 during the same word period. In single-lane operation, the I word and then the Q word leave back to back on lane 0, and lane 1 stays low. The wide format has twice the bits per rail of a 16-bit word. At an equal sample rate, the serial clock must therefore run twice as fast as it would for 16-bit words. A strobe marks the first bit of every frame.

Samples arrive with a valid pulse. A sample that arrives while a frame is still shifting waits in a one-entry holding slot. The format and lane selections take effect only when a frame starts.

Top module: `rx_iq_serializer`

## Requirements
- R1: In the wide format (`cfg_wide`=1), each rail word is 32 bits, from MSB down: sample[21:0] in bits 31:10, a 0 in bit 9, the gain-change flag in bit 8, and gain[7:0] in bits 7:0.
- R2: In the wide format with a single lane (`cfg_single`=1), lane 0 sends a 64-bit frame: the whole I word, then the whole Q word.
- R3: In the slim format (`cfg_wide`=0), each rail word is 16 bits: the rounded sample in bits 15:1 and the gain-change flag in bit 0. The rounded sample is bits 21:7 of the signed sample plus 64 (round half up).
- R4: When rounding a positive sample would overflow 15 bits, the slim sample becomes 15'h3FFF instead of wrapping.
- R5: In the slim format with a single lane, lane 0 sends a 32-bit frame: the I word, then the Q word.
- R6: With two lanes (`cfg_single`=0), the I word is sent on lane 0 and the Q word on lane 1, in the same cycles. With a single lane, lane 1 stays 0.
- R7: Bits leave MSB first, and the first bit appears in the cycle after the sample is taken. `frame_strobe` is high during the first bit of a frame and low during every other bit.
- R8: A sample that arrives during a frame is held and starts in the cycle right after the last bit of the current frame, with no idle gap.
- R9: A sample that arrives while the holding slot is full raises `overflow` for exactly one cycle and is dropped; the held sample is kept.
- R10: `cfg_wide` and `cfg_single` are sampled only when a frame starts. Changing them mid-frame alters neither the length nor the content of that frame.
- R11: After reset and whenever no frame is shifting, both lanes, `frame_strobe` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | New sample present this cycle |
| in_i | input | 22 | I sample, two's complement |
| in_q | input | 22 | Q sample, two's complement |
| in_gain_chg | input | 1 | Gain-change flag |
| in_gain | input | 8 | Gain index |
| cfg_wide | input | 1 | 1: 32-bit rail words, 0: 16-bit rounded words |
| cfg_single | input | 1 | 1: I and Q share lane 0, 0: one lane per rail |
| lane0_dout | output | 1 | Serial lane 0 (I, or I then Q) |
| lane1_dout | output | 1 | Serial lane 1 (Q in two-lane operation) |
| frame_strobe | output | 1 | High with the first bit of each frame |
| overflow | output | 1 | One-cycle pulse when a sample is dropped |

## Verification
The hardest state to reach is the holding slot being full while a frame is still shifting, with a third sample arriving on top of it. The stimulus starts a 32-bit frame, then inserts a second sample and a third sample in consecutive cycles a few bits into that frame. The bench then checks three things: the overflow pulse lasts exactly one cycle, the second sample's frame follows the first with no gap, and no frame ever appears for the third sample. A second hard case is a format change in the middle of a frame. It is reached by flipping `cfg_wide` one bit after a frame starts and then checking the length and content of that frame.

// File: rtl/rx_iq_pkg.sv
package rx_iq_pkg;
    parameter int SAMP_W   = 22;
    parameter int GAIN_W   = 8;
    parameter int SLIM_S_W = 15;
    localparam int WIDE_W  = SAMP_W + 2 + GAIN_W;
    localparam int SLIM_W  = SLIM_S_W + 1;
    localparam int FRAME_W = 2 * WIDE_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic [SAMP_W-1:0] i;
        logic [SAMP_W-1:0] q;
        logic              chg;
        logic [GAIN_W-1:0] gain;
    } sample_t;
endpackage

// File: rtl/rx_iq_round.sv
module rx_iq_round #(
    parameter int IN_W  = 22,
    parameter int OUT_W = 15
) (
    input  logic [IN_W-1:0]  s_in,
    output logic [OUT_W-1:0] s_out
);
    localparam int DROP = IN_W - OUT_W;
    localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (DROP - 1);

    logic [IN_W:0] sum;
    logic          ovf;

    always_comb begin
        sum   = {s_in[IN_W-1], s_in} + HALF;
        ovf   = (sum[IN_W:IN_W-1] == 2'b01);
        s_out = ovf ? {1'b0, {(OUT_W-1){1'b1}}} : sum[IN_W-1:DROP];
    end
endmodule

// File: rtl/rx_iq_fmt.sv
module rx_iq_fmt
    import rx_iq_pkg::*;
(
    input  sample_t                smp,
    input  logic                   wide,
    input  logic                   single,
    output logic [FRAME_W-1:0]     frame0,
    output logic [WIDE_W-1:0]      frame1,
    output logic [CNT_W-1:0]       last_idx
);
    logic [SAMP_W-1:0] rail   [2];
    logic [WIDE_W-1:0] wword  [2];
    logic [SLIM_W-1:0] sword  [2];

    assign rail[0] = smp.i;
    assign rail[1] = smp.q;

    for (genvar r = 0; r < 2; r++) begin : g_rail
        logic [SLIM_S_W-1:0] rnd;
        rx_iq_round #(.IN_W(SAMP_W), .OUT_W(SLIM_S_W)) u_round (
            .s_in  (rail[r]),
            .s_out (rnd)
        );
        assign wword[r] = {rail[r], 1'b0, smp.chg, smp.gain};
        assign sword[r] = {rnd, smp.chg};
    end

    always_comb begin
        frame0   = '0;
        frame1   = '0;
        last_idx = '0;
        unique case ({wide, single})
            2'b11: begin
                frame0   = {wword[0], wword[1]};
                last_idx = CNT_W'(2 * WIDE_W - 1);
            end
            2'b10: begin
                frame0[FRAME_W-1 -: WIDE_W] = wword[0];
                frame1                      = wword[1];
                last_idx                    = CNT_W'(WIDE_W - 1);
            end
            2'b01: begin
                frame0[FRAME_W-1 -: 2*SLIM_W] = {sword[0], sword[1]};
                last_idx                      = CNT_W'(2 * SLIM_W - 1);
            end
            default: begin
                frame0[FRAME_W-1 -: SLIM_W] = sword[0];
                frame1[WIDE_W-1 -: SLIM_W]  = sword[1];
                last_idx                    = CNT_W'(SLIM_W - 1);
            end
        endcase
    end
endmodule

// File: rtl/rx_iq_serializer.sv
module rx_iq_serializer
    import rx_iq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_i,
    input  logic [SAMP_W-1:0] in_q,
    input  logic              in_gain_chg,
    input  logic [GAIN_W-1:0] in_gain,
    input  logic              cfg_wide,
    input  logic              cfg_single,
    output logic              lane0_dout,
    output logic              lane1_dout,
    output logic              frame_strobe,
    output logic              overflow
);
    typedef struct packed {
        logic [FRAME_W-1:0] sh0;
        logic [WIDE_W-1:0]  sh1;
        logic [CNT_W-1:0]   cnt;
        logic               active;
        logic               strobe;
        logic               ovf;
        logic               hold_v;
        sample_t            hold;
    } state_t;

    state_t d, q;

    sample_t            in_smp;
    sample_t            ld_smp;
    logic               ld;
    logic               boundary;
    logic [FRAME_W-1:0] f0;
    logic [WIDE_W-1:0]  f1;
    logic [CNT_W-1:0]   f_last;

    assign in_smp = '{i: in_i, q: in_q, chg: in_gain_chg, gain: in_gain};

    rx_iq_fmt u_fmt (
        .smp      (ld_smp),
        .wide     (cfg_wide),
        .single   (cfg_single),
        .frame0   (f0),
        .frame1   (f1),
        .last_idx (f_last)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        d.ovf    = 1'b0;
        d.sh0    = q.sh0 << 1;
        d.sh1    = q.sh1 << 1;
        boundary = !q.active || (q.cnt == '0);
        ld       = 1'b0;
        ld_smp   = in_smp;

        if (boundary) begin
            d.active = 1'b0;
            if (q.hold_v) begin
                ld       = 1'b1;
                ld_smp   = q.hold;
                d.hold_v = in_valid;
                if (in_valid) d.hold = in_smp;
            end else if (in_valid) begin
                ld = 1'b1;
            end
        end else begin
            d.cnt = q.cnt - 1'b1;
            if (in_valid) begin
                if (!q.hold_v) begin
                    d.hold_v = 1'b1;
                    d.hold   = in_smp;
                end else begin
                    d.ovf = 1'b1;
                end
            end
        end

        if (ld) begin
            d.sh0    = f0;
            d.sh1    = f1;
            d.cnt    = f_last;
            d.active = 1'b1;
            d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lane0_dout   = q.sh0[FRAME_W-1];
    assign lane1_dout   = q.sh1[WIDE_W-1];
    assign frame_strobe = q.strobe;
    assign overflow     = q.ovf;
endmodule

module rx_iq_serializer_chk
    import rx_iq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             lane0_dout,
    input logic             lane1_dout,
    input logic             frame_strobe,
    input logic             overflow,
    input logic             active,
    input logic [CNT_W-1:0] cnt
);
    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |=> !frame_strobe);
    // R7
    strobe_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> active);
    // R9
    overflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> $past(in_valid));
    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != '0) |=> (active && cnt == $past(cnt) - 1'b1));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!lane0_dout && !lane1_dout && !frame_strobe));
endmodule

bind rx_iq_serializer rx_iq_serializer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .lane0_dout   (lane0_dout),
    .lane1_dout   (lane1_dout),
    .frame_strobe (frame_strobe),
    .overflow     (overflow),
    .active       (q.active),
    .cnt          (q.cnt)
);

// File: tb/rx_iq_serializer_tb.sv
module rx_iq_serializer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [21:0] in_i = '0;
    logic [21:0] in_q = '0;
    logic        in_gain_chg = 1'b0;
    logic [7:0]  in_gain = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_single = 1'b0;
    logic        lane0_dout, lane1_dout, frame_strobe, overflow;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rx_iq_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .in_gain_chg(in_gain_chg), .in_gain(in_gain), .cfg_wide(cfg_wide),
        .cfg_single(cfg_single), .lane0_dout(lane0_dout), .lane1_dout(lane1_dout),
        .frame_strobe(frame_strobe), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wword(input logic [21:0] s, input logic c, input logic [7:0] g);
        return {s, 1'b0, c, g};
    endfunction

    function automatic logic [14:0] rnd(input logic [21:0] s);
        int v;
        v = $signed(s);
        v = (v + 64) >>> 7;
        if (v > 16383) v = 16383;
        return v[14:0];
    endfunction

    function automatic logic [15:0] sword(input logic [21:0] s, input logic c);
        return {rnd(s), c};
    endfunction

    task automatic push(input logic [21:0] i, input logic [21:0] qv, input logic c, input logic [7:0] g);
        in_i = i; in_q = qv; in_gain_chg = c; in_gain = g; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic capture(input int len, input string req,
                           output logic [63:0] g0, output logic [63:0] g1);
        g0 = '0; g1 = '0;
        for (int n = 0; n < len; n++) begin
            g0 = {g0[62:0], lane0_dout};
            g1 = {g1[62:0], lane1_dout};
            check(frame_strobe == (n == 0), "R7", $sformatf("%s strobe bit %0d", req, n),
                  64'(frame_strobe), 64'(n == 0));
            @(negedge clk);
        end
    endtask

    task automatic expect_idle(input string req);
        check(!frame_strobe && !lane0_dout && !lane1_dout && !overflow, "R11",
              {req, " idle after frame"},
              {60'd0, frame_strobe, lane0_dout, lane1_dout, overflow}, 64'd0);
    endtask

    task automatic t_reset;
        check(!lane0_dout && !lane1_dout && !frame_strobe && !overflow, "R11", "reset state",
              {60'd0, lane0_dout, lane1_dout, frame_strobe, overflow}, 64'd0);
    endtask

    task automatic t_wide_dual;
        logic [63:0] g0, g1;
        cfg_wide = 1; cfg_single = 0;
        push(22'h2A5C31, 22'h13579B, 1'b1, 8'hC3);
        capture(32, "R1", g0, g1);
        check(g0[31:0] == wword(22'h2A5C31, 1, 8'hC3), "R1", "wide I lane0", g0, 64'(wword(22'h2A5C31, 1, 8'hC3)));
        check(g1[31:0] == wword(22'h13579B, 1, 8'hC3), "R6", "wide Q lane1", g1, 64'(wword(22'h13579B, 1, 8'hC3)));
        expect_idle("R1");
    endtask

    task automatic t_wide_single;
        logic [63:0] g0, g1, e;
        cfg_wide = 1; cfg_single = 1;
        e = {wword(22'h3FFFFF, 0, 8'h5A), wword(22'h000001, 0, 8'h5A)};
        push(22'h3FFFFF, 22'h000001, 1'b0, 8'h5A);
        capture(64, "R2", g0, g1);
        check(g0 == e, "R2", "wide single frame", g0, e);
        check(g1 == 64'd0, "R6", "lane1 quiet single", g1, 64'd0);
        expect_idle("R2");
    endtask

    task automatic t_slim_dual;
        logic [63:0] g0, g1;
        cfg_wide = 0; cfg_single = 0;
        push(22'h000040, 22'h3FFFBF, 1'b1, 8'h00);
        capture(16, "R3", g0, g1);
        check(g0[15:0] == 16'h0003, "R3", "round half up I", g0, 64'h3);
        check(g1[15:0] == 16'hFFFF, "R3", "round negative Q", g1, 64'hFFFF);
        check(g0[15:0] == sword(22'h000040, 1), "R6", "slim I lane0", g0, 64'(sword(22'h000040, 1)));
        expect_idle("R3");
        push(22'h1FFFFF, 22'h0000BF, 1'b0, 8'h11);
        capture(16, "R4", g0, g1);
        check(g0[15:0] == 16'h7FFE, "R4", "saturate I", g0, 64'h7FFE);
        check(g1[15:0] == sword(22'h0000BF, 0), "R3", "round Q 191", g1, 64'(sword(22'h0000BF, 0)));
        expect_idle("R4");
    endtask

    task automatic t_slim_single;
        logic [63:0] g0, g1, e;
        cfg_wide = 0; cfg_single = 1;
        e = 64'({sword(22'h3FFFC0, 1), sword(22'h1FFFC0, 1)});
        push(22'h3FFFC0, 22'h1FFFC0, 1'b1, 8'hFF);
        capture(32, "R5", g0, g1);
        check(g0 == e, "R5", "slim single frame", g0, e);
        check(g1 == 64'd0, "R6", "lane1 quiet slim single", g1, 64'd0);
        expect_idle("R5");
    endtask

    task automatic t_buffer_overflow;
        logic [63:0] g0, g1, a0, a1;
        cfg_wide = 1; cfg_single = 0;
        push(22'h111111, 22'h222222, 1'b0, 8'h01);
        a0 = '0; a1 = '0;
        for (int n = 0; n < 32; n++) begin
            a0 = {a0[62:0], lane0_dout};
            a1 = {a1[62:0], lane1_dout};
            if (n == 4) check(overflow == 1'b1, "R9", "overflow pulse", 64'(overflow), 64'd1);
            if (n == 5) check(overflow == 1'b0, "R9", "overflow one cycle", 64'(overflow), 64'd0);
            if (n == 2) begin
                in_i = 22'h0ABCDE; in_q = 22'h354321; in_gain_chg = 1; in_gain = 8'h77; in_valid = 1;
            end else if (n == 3) begin
                in_i = 22'h3C3C3C; in_q = 22'h0F0F0F; in_gain_chg = 0; in_gain = 8'h99; in_valid = 1;
            end else begin
                in_valid = 0;
            end
            @(negedge clk);
        end
        check(a0[31:0] == wword(22'h111111, 0, 8'h01), "R8", "first frame intact", a0, 64'(wword(22'h111111, 0, 8'h01)));
        capture(32, "R8", g0, g1);
        check(g0[31:0] == wword(22'h0ABCDE, 1, 8'h77), "R8", "held frame back to back I", g0, 64'(wword(22'h0ABCDE, 1, 8'h77)));
        check(g1[31:0] == wword(22'h354321, 1, 8'h77), "R9", "held sample kept Q", g1, 64'(wword(22'h354321, 1, 8'h77)));
        check(frame_strobe == 1'b0, "R9", "dropped sample never sent", 64'(frame_strobe), 64'd0);
        expect_idle("R9");
    endtask

    task automatic t_mode_change;
        logic [63:0] g0, g1;
        cfg_wide = 1; cfg_single = 0;
        push(22'h2DB6DB, 22'h124924, 1'b1, 8'hA5);
        g0 = '0; g1 = '0;
        for (int n = 0; n < 32; n++) begin
            g0 = {g0[62:0], lane0_dout};
            g1 = {g1[62:0], lane1_dout};
            if (n == 1) begin cfg_wide = 0; cfg_single = 1; end
            @(negedge clk);
        end
        check(g0[31:0] == wword(22'h2DB6DB, 1, 8'hA5), "R10", "mode change keeps I", g0, 64'(wword(22'h2DB6DB, 1, 8'hA5)));
        check(g1[31:0] == wword(22'h124924, 1, 8'hA5), "R10", "mode change keeps Q", g1, 64'(wword(22'h124924, 1, 8'hA5)));
        expect_idle("R10");
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wide_dual();
        t_wide_single();
        t_slim_dual();
        t_slim_single();
        t_buffer_overflow();
        t_mode_change();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule